// File: doc/BRIEF.md
# ATA PIO Strobe Timing Calculator

This block turns a requested ATA PIO transfer mode into the cycle counts that a parallel-bus strobe sequencer loads into its timing fields. For each mode it knows three nanosecond figures: address-to-strobe setup, strobe width and post-strobe hold. It also knows whether the device may stretch the cycle through its IORDY line. The clock frequency is fixed by a parameter. The block converts each figure to clock cycles, rounding up, and stores every count in minus-one form.

The sequencer's fields are narrow (6 bits by default). When the strobe width does not fit its field, the block halves all three counts together, rounding up, and doubles a shared time multiplier. It repeats this one step per clock until the strobe count fits. It then reports the multiplier in the sequencer's 2-bit code. That code is not monotonic: 1 becomes 01, 2 becomes 10, 4 becomes 00, and 8 or more becomes 11.

A request is a valid/ready handshake carrying the 3-bit mode. Back-pressure rules: a request is taken only on a clock edge where both `req_valid` and `req_ready` are high. `req_ready` stays low while a calculation runs, and a `req_valid` raised during that time is not queued and has no effect. The result side has no back-pressure. `res_done` pulses for one cycle, and the result ports keep their values until the next request is taken.

Top module: `pio_timing_calc`

## Requirements
- R1: After reset, `req_ready` is 1, `res_done` is 0, the setup, strobe and hold outputs and `res_iordy` are 0, and `res_mult_code` is 01 (multiplier 1).
- R2: A request is taken on an edge with `req_valid` and `req_ready` both high. From that edge until the edge that raises `res_done`, `req_ready` is 0, and `req_valid` pulses in that window are ignored: they start no calculation and do not alter the pending result.
- R3: The nanosecond figures per mode (setup/strobe/hold) are 70/165/20 for mode 0, 50/125/15 for mode 1, 30/100/10 for mode 2, 30/80/10 for mode 3, 25/70/10 for mode 4, 15/65/10 for mode 5 and 10/55/10 for mode 6.
- R4: `res_iordy` is 1 for modes 0 through 4 and 0 for modes 5 and 6.
- R5: Clocks per microsecond is CLK_HZ/1,000,000 rounded up, written C. Each count is ceil(ns × C / 1000), then reduced by one when it is nonzero.
- R6: While the strobe count is 2^FIELD_W or more, all three counts are replaced by (count+1)/2 (integer division) and the multiplier doubles, one step per clock, starting from a multiplier of 1.
- R7: `res_mult_code` encodes the final multiplier as 1→01, 2→10, 4→00, and 8 or more →11.
- R8: `res_done` is high for exactly one cycle, on the edge 2+n cycles after the accepting edge, where n is the number of halving steps. The result ports then hold their values until the next request is taken.
- R9: A mode value of 7 gives exactly the results of mode 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_mode | input | 3 | Requested PIO mode (7 treated as 0) |
| res_done | output | 1 | One-cycle pulse: result ports are valid |
| res_setup | output | FIELD_W | Setup cycles, minus-one form, scaled |
| res_strobe | output | FIELD_W | Strobe width cycles, minus-one form, scaled |
| res_hold | output | FIELD_W | Hold cycles, minus-one form, scaled |
| res_iordy | output | 1 | IORDY wait enable for the mode |
| res_mult_code | output | 2 | Encoded time multiplier |

## Verification
The bench uses three clock settings so that every multiplier code appears, including the out-of-order 00 for a multiplier of 4. A design that emitted the plain log2 of the multiplier would fail here, and so would one that stopped doubling at 8. The 1 MHz setting gives raw counts of exactly 1 for every figure. Those counts must come out as 0, so a design that dropped or misapplied the minus-one step is caught. Halving with truncation instead of round-up shows up as setup and hold values one too low in the scaled modes. Completion latency is measured for 0 to 4 halving steps, which exposes a loop that runs one step too many or too few. A request raised while the block is busy must neither corrupt the result nor produce a second completion pulse.

// File: rtl/pio_calc_pkg.sv
package pio_calc_pkg;
  localparam int NS_W   = 8;
  localparam int MODE_W = 3;
  localparam int NPARAM = 3;
  localparam int LOG_W  = 5;

  localparam int IDX_SETUP  = 0;
  localparam int IDX_STROBE = 1;
  localparam int IDX_HOLD   = 2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CONV  = 2'd1,
    ST_SCALE = 2'd2
  } calc_state_e;

  typedef struct packed {
    logic [NS_W-1:0] setup_ns;
    logic [NS_W-1:0] strobe_ns;
    logic [NS_W-1:0] hold_ns;
    logic            iordy_en;
  } mode_ns_t;

  // Sequencer multiplier code from log2 of the multiplier.
  function automatic logic [1:0] mult_code(input logic [LOG_W-1:0] lg);
    case (lg)
      5'd0:    return 2'b01;
      5'd1:    return 2'b10;
      5'd2:    return 2'b00;
      default: return 2'b11;
    endcase
  endfunction
endpackage

// File: rtl/pio_mode_table.sv
module pio_mode_table
  import pio_calc_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  output mode_ns_t          entry
);
  always_comb begin
    case (mode)
      3'd1:    entry = '{setup_ns: 8'd50, strobe_ns: 8'd125, hold_ns: 8'd15, iordy_en: 1'b1};
      3'd2:    entry = '{setup_ns: 8'd30, strobe_ns: 8'd100, hold_ns: 8'd10, iordy_en: 1'b1};
      3'd3:    entry = '{setup_ns: 8'd30, strobe_ns: 8'd80,  hold_ns: 8'd10, iordy_en: 1'b1};
      3'd4:    entry = '{setup_ns: 8'd25, strobe_ns: 8'd70,  hold_ns: 8'd10, iordy_en: 1'b1};
      3'd5:    entry = '{setup_ns: 8'd15, strobe_ns: 8'd65,  hold_ns: 8'd10, iordy_en: 1'b0};
      3'd6:    entry = '{setup_ns: 8'd10, strobe_ns: 8'd55,  hold_ns: 8'd10, iordy_en: 1'b0};
      default: entry = '{setup_ns: 8'd70, strobe_ns: 8'd165, hold_ns: 8'd20, iordy_en: 1'b1}; // mode 0 and 7 (R9)
    endcase
  end
endmodule

// File: rtl/pio_ns_to_cyc.sv
module pio_ns_to_cyc #(
  parameter int CPU   = 600,
  parameter int NS_W  = 8,
  parameter int CYC_W = 8
) (
  input  logic [NS_W-1:0]  ns,
  output logic [CYC_W-1:0] cyc
);
  localparam int PROD_W = NS_W + $clog2(CPU + 1) + 10;

  logic [PROD_W-1:0] prod;
  logic [PROD_W-1:0] ceil_q;

  always_comb begin
    prod   = PROD_W'(ns) * PROD_W'(CPU);
    ceil_q = (prod + PROD_W'(999)) / PROD_W'(1000);
    if (ceil_q == '0) cyc = '0;
    else              cyc = CYC_W'(ceil_q - PROD_W'(1)); // minus-one form, R5
  end

  always_comb begin
    if (ns != '0) assert (ceil_q != '0); // R5 nonzero time never rounds to zero cycles
  end
endmodule

// File: rtl/pio_scale_ctrl.sv
module pio_scale_ctrl
  import pio_calc_pkg::*;
#(
  parameter int CYC_W   = 8,
  parameter int FIELD_W = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [MODE_W-1:0]    req_mode,
  output logic                 req_ready,
  output logic [MODE_W-1:0]    mode_q,
  input  logic [CYC_W-1:0]     conv_cyc [NPARAM],
  input  logic                 conv_iordy,
  output logic [CYC_W-1:0]     work     [NPARAM],
  output logic                 iordy_q,
  output logic [LOG_W-1:0]     mult_log,
  output logic                 done
);
  localparam logic [CYC_W-1:0] LIMIT = CYC_W'(1) << FIELD_W;

  calc_state_e state;
  logic        too_wide;

  assign too_wide  = (work[IDX_STROBE] >= LIMIT);
  assign req_ready = (state == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      mode_q   <= '0;
      iordy_q  <= 1'b0;
      mult_log <= '0;
      done     <= 1'b0;
      for (int i = 0; i < NPARAM; i++) work[i] <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            mode_q <= req_mode;
            state  <= ST_CONV;
          end
        end
        ST_CONV: begin
          for (int i = 0; i < NPARAM; i++) work[i] <= conv_cyc[i];
          iordy_q  <= conv_iordy;
          mult_log <= '0;
          state    <= ST_SCALE;
        end
        ST_SCALE: begin
          if (too_wide) begin
            for (int i = 0; i < NPARAM; i++)
              work[i] <= CYC_W'(({1'b0, work[i]} + (CYC_W+1)'(1)) >> 1);
            mult_log <= mult_log + LOG_W'(1);
          end else begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_FIT_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (work[IDX_STROBE] < LIMIT)); // R6
  AST_HALVE_DOUBLES: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SCALE && too_wide) |=> (mult_log == $past(mult_log) + LOG_W'(1))); // R6
  AST_BUSY_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |=> $stable(mode_q)); // R2
  AST_READY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready); // R2
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !req_valid) |=> $stable(work[IDX_STROBE]) && $stable(mult_log)); // R8
endmodule

// File: rtl/pio_timing_calc.sv
module pio_timing_calc
  import pio_calc_pkg::*;
#(
  parameter int unsigned CLK_HZ  = 600_000_000,
  parameter int          FIELD_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [MODE_W-1:0]  req_mode,
  output logic               res_done,
  output logic [FIELD_W-1:0] res_setup,
  output logic [FIELD_W-1:0] res_strobe,
  output logic [FIELD_W-1:0] res_hold,
  output logic               res_iordy,
  output logic [1:0]         res_mult_code
);
  localparam longint unsigned CPU_L = (64'(CLK_HZ) + 64'd999_999) / 64'd1_000_000;
  localparam int CPU     = int'(CPU_L);
  localparam int CYC_RAW = $clog2(((1 << NS_W) - 1) * CPU / 1000 + 2);
  localparam int CYC_W   = (CYC_RAW > FIELD_W) ? CYC_RAW : FIELD_W + 1;

  logic [MODE_W-1:0] mode_q;
  mode_ns_t          entry;
  logic [NS_W-1:0]   ns_arr   [NPARAM];
  logic [CYC_W-1:0]  conv_cyc [NPARAM];
  logic [CYC_W-1:0]  work     [NPARAM];
  logic [LOG_W-1:0]  mult_log;

  pio_mode_table u_table (
    .mode  (mode_q),
    .entry (entry)
  );

  assign ns_arr[IDX_SETUP]  = entry.setup_ns;
  assign ns_arr[IDX_STROBE] = entry.strobe_ns;
  assign ns_arr[IDX_HOLD]   = entry.hold_ns;

  for (genvar g = 0; g < NPARAM; g++) begin : g_conv
    pio_ns_to_cyc #(
      .CPU   (CPU),
      .NS_W  (NS_W),
      .CYC_W (CYC_W)
    ) u_conv (
      .ns  (ns_arr[g]),
      .cyc (conv_cyc[g])
    );
  end

  pio_scale_ctrl #(
    .CYC_W   (CYC_W),
    .FIELD_W (FIELD_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_mode   (req_mode),
    .req_ready  (req_ready),
    .mode_q     (mode_q),
    .conv_cyc   (conv_cyc),
    .conv_iordy (entry.iordy_en),
    .work       (work),
    .iordy_q    (res_iordy),
    .mult_log   (mult_log),
    .done       (res_done)
  );

  assign res_setup     = FIELD_W'(work[IDX_SETUP]);
  assign res_strobe    = FIELD_W'(work[IDX_STROBE]);
  assign res_hold      = FIELD_W'(work[IDX_HOLD]);
  assign res_mult_code = mult_code(mult_log);

  AST_ORDER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    res_done |-> (work[IDX_SETUP] <= work[IDX_STROBE]) && (work[IDX_HOLD] <= work[IDX_STROBE])); // R3
  AST_FAST_NO_IORDY: assert property (@(posedge clk) disable iff (!rst_n)
    (res_done && (mode_q == 3'd5 || mode_q == 3'd6)) |-> !res_iordy); // R4
  AST_CODE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (res_done && work[IDX_STROBE] >= CYC_W'(1 << (FIELD_W - 1)) && mult_log == '0) |-> (res_mult_code == 2'b01)); // R7
endmodule

// File: tb/tb_pio_timing_calc.sv
module tb_pio_timing_calc;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n;
  logic       vld  [3];
  logic [2:0] mode_in [3];
  logic       rdy  [3];
  logic       done [3];
  logic [5:0] st [3];
  logic [5:0] sb [3];
  logic [5:0] hd [3];
  logic       io [3];
  logic [1:0] code [3];

  int checks = 0;
  int errors = 0;

  pio_timing_calc #(.CLK_HZ(32'd600000000)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(vld[0]), .req_ready(rdy[0]), .req_mode(mode_in[0]),
    .res_done(done[0]), .res_setup(st[0]), .res_strobe(sb[0]), .res_hold(hd[0]),
    .res_iordy(io[0]), .res_mult_code(code[0]));

  pio_timing_calc #(.CLK_HZ(32'd3499999001)) dut_fast (
    .clk(clk), .rst_n(rst_n), .req_valid(vld[1]), .req_ready(rdy[1]), .req_mode(mode_in[1]),
    .res_done(done[1]), .res_setup(st[1]), .res_strobe(sb[1]), .res_hold(hd[1]),
    .res_iordy(io[1]), .res_mult_code(code[1]));

  pio_timing_calc #(.CLK_HZ(32'd1000000)) dut_slow (
    .clk(clk), .rst_n(rst_n), .req_valid(vld[2]), .req_ready(rdy[2]), .req_mode(mode_in[2]),
    .res_done(done[2]), .res_setup(st[2]), .res_strobe(sb[2]), .res_hold(hd[2]),
    .res_iordy(io[2]), .res_mult_code(code[2]));

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Issue one request on instance idx and measure edges until done.
  task automatic issue(input int idx, input logic [2:0] m, output int lat);
    @(negedge clk);
    vld[idx] = 1'b1;
    mode_in[idx] = m;
    @(posedge clk);
    @(negedge clk);
    vld[idx] = 1'b0;
    chk("R2", "ready low after accept", int'(rdy[idx]), 0);
    lat = 0;
    while (!done[idx] && lat < 100) begin
      @(posedge clk);
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic run_and_check(input int idx, input logic [2:0] m, input int e_st, input int e_sb,
                               input int e_hd, input int e_io, input int e_code, input int e_lat);
    int lat;
    issue(idx, m, lat);
    chk("R8", $sformatf("latency inst%0d mode%0d", idx, m), lat, e_lat);
    chk("R5", $sformatf("setup inst%0d mode%0d", idx, m), int'(st[idx]), e_st);
    chk("R3", $sformatf("strobe inst%0d mode%0d", idx, m), int'(sb[idx]), e_sb);
    chk("R6", $sformatf("hold inst%0d mode%0d", idx, m), int'(hd[idx]), e_hd);
    chk("R4", $sformatf("iordy inst%0d mode%0d", idx, m), int'(io[idx]), e_io);
    chk("R7", $sformatf("code inst%0d mode%0d", idx, m), int'(code[idx]), e_code);
    chk("R2", "ready back at done", int'(rdy[idx]), 1);
  endtask

  task automatic t_reset();
    for (int i = 0; i < 3; i++) begin
      chk("R1", "ready", int'(rdy[i]), 1);
      chk("R1", "done", int'(done[i]), 0);
      chk("R1", "outputs", int'(st[i]) + int'(sb[i]) + int'(hd[i]) + int'(io[i]), 0);
      chk("R1", "code", int'(code[i]), 1);
    end
  endtask

  task automatic t_main_modes();
    int e_st [7] = '{21, 15, 17, 17, 14, 8, 5};
    int e_sb [7] = '{49, 37, 59, 47, 41, 38, 32};
    int e_hd [7] = '{6, 4, 5, 5, 5, 5, 5};
    int e_io [7] = '{1, 1, 1, 1, 1, 0, 0};
    int e_cd [7] = '{2, 2, 1, 1, 1, 1, 1};
    int e_lt [7] = '{3, 3, 2, 2, 2, 2, 2};
    for (int m = 0; m < 7; m++)
      run_and_check(0, 3'(m), e_st[m], e_sb[m], e_hd[m], e_io[m], e_cd[m], e_lt[m]);
  endtask

  task automatic t_fast_clock();
    run_and_check(1, 3'd0, 16, 37, 5, 1, 3, 6); // R7 multiplier 16 -> 11
    run_and_check(1, 3'd3, 13, 35, 5, 1, 3, 5); // R7 multiplier 8 -> 11
    run_and_check(1, 3'd6, 9, 48, 9, 0, 0, 4);  // R7 multiplier 4 -> 00
  endtask

  task automatic t_slow_clock();
    run_and_check(2, 3'd0, 0, 0, 0, 1, 1, 2); // R5 count of 1 becomes 0
    run_and_check(2, 3'd5, 0, 0, 0, 0, 1, 2);
  endtask

  task automatic t_mode7();
    run_and_check(0, 3'd7, 21, 49, 6, 1, 2, 3); // R9
  endtask

  task automatic t_busy_ignored();
    int lat;
    int extra;
    @(negedge clk);
    vld[0] = 1'b1;
    mode_in[0] = 3'd0;
    @(posedge clk);
    @(negedge clk);
    mode_in[0] = 3'd6; // still valid while busy
    @(posedge clk);
    @(negedge clk);
    vld[0] = 1'b0;
    lat = 1;
    while (!done[0] && lat < 100) begin
      @(posedge clk);
      @(negedge clk);
      lat++;
    end
    chk("R2", "busy latency", lat, 3);
    chk("R2", "busy strobe kept mode0", int'(sb[0]), 49);
    chk("R2", "busy setup kept mode0", int'(st[0]), 21);
    extra = 0;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      if (done[0]) extra++;
    end
    chk("R2", "no second done", extra, 0);
    chk("R8", "hold after done strobe", int'(sb[0]), 49);
    chk("R8", "hold after done code", int'(code[0]), 2);
  endtask

  task automatic t_hold();
    int lat;
    int moved;
    issue(0, 3'd4, lat);
    moved = 0;
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      if (done[0] || st[0] != 6'd14 || sb[0] != 6'd41 || hd[0] != 6'd5) moved++;
    end
    chk("R8", "outputs held, done single", moved, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 3; i++) begin
      vld[i] = 1'b0;
      mode_in[i] = 3'd0;
    end
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_main_modes();
    t_fast_clock();
    t_slow_clock();
    t_mode7();
    t_busy_ignored();
    t_hold();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule